// File: doc/BRIEF.md
# Segment table address translator

This block maps a 32-bit virtual address onto a physical address through a small table of segments. The two top address bits pick one of four segments and the remaining 30 bits form the offset into it. Each table entry holds four fields: a presence flag, a 32-bit physical base, a 30-bit inclusive limit on the offset, and a flag that allows writes. A request that passes every check returns base plus offset. A request that fails any check returns a fault code and no address.

The table is loaded through a configuration write port. That port only takes effect when the privileged qualifier is high. On a process switch, software rewrites all four entries with the next process's values. If only one entry is ever loaded, the block behaves as a single base-and-limit translator.

Translation is combinational from the request. The result is captured in one output register, so every result appears on the clock edge after its request is sampled.

Top module: `seg_xlate`

## Requirements
- R1: The segment index is `req_va[31:30]` and the offset is `req_va[29:0]`. Both are taken from the same request word.
- R2: A request to a present segment passes when three conditions hold: the offset is not above the entry's limit, the access is a read or the entry allows writes, and no other check fails. A passing request yields `rsp_ok=1`, `rsp_fault=0` and `rsp_pa` = base + offset, taken modulo 2^32.
- R3: A request to a segment whose presence flag is clear yields `rsp_fault=1`.
- R4: A request whose offset is strictly greater than the entry's limit yields `rsp_fault=2`. An offset equal to the limit passes.
- R5: A write (`req_write=1`) to an entry whose write flag is clear yields `rsp_fault=3`. A read of the same entry passes.
- R6: When several checks fail at once, the lowest code wins: absent (1) is reported before limit (2), and limit (2) before write protection (3).
- R7: Any faulting response has `rsp_ok=0` and `rsp_pa=0`.
- R8: A request sampled on one rising edge gives `rsp_valid=1` after that edge. In a cycle with no request sampled, the outputs after the edge are `rsp_valid=0`, `rsp_ok=0`, `rsp_fault=0` and `rsp_pa=0`.
- R9: A table write with `cfg_priv=0` changes no entry.
- R10: If a table write and a request are sampled on the same edge, the request is translated with the entry as it was before the write.
- R11: After reset, every entry is absent and the outputs are idle.
- R12: Rewriting an entry fully replaces its base, limit, write flag and presence flag for all later requests. This is how the table is reloaded on a process switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| cfg_we | input | 1 | Table write strobe |
| cfg_priv | input | 1 | Write issued in privileged mode |
| cfg_idx | input | 2 | Entry to write |
| cfg_present | input | 1 | New presence flag |
| cfg_base | input | 32 | New physical base |
| cfg_limit | input | 30 | New inclusive offset limit |
| cfg_wr_ok | input | 1 | New write-allow flag |
| rsp_valid | output | 1 | Result present |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_pa | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 2 | 0 none, 1 absent, 2 limit, 3 write protect |

## Verification
The assertions check several response properties on every cycle. The pass flag must agree with a zero fault code, and a fault must carry a zero address. Each response must follow its request by exactly one edge, and idle cycles must leave the outputs quiet. A write-protect fault may only come from a write.

Other behaviour depends on the table contents and can only be shown by the bench's scenarios. This covers the address arithmetic and its wrap-around, the inclusive limit edge, and the fault priority order. It also covers rejected unprivileged writes, the old-entry rule for a write on the same edge, and the full reload on a process switch.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int AW       = 32,
  parameter int SEG_BITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [AW-1:0]       req_va,
  input  logic                req_write,
  input  logic                cfg_we,
  input  logic                cfg_priv,
  input  logic [SEG_BITS-1:0] cfg_idx,
  input  logic                cfg_present,
  input  logic [AW-1:0]       cfg_base,
  input  logic [AW-SEG_BITS-1:0] cfg_limit,
  input  logic                cfg_wr_ok,
  output logic                rsp_valid,
  output logic                rsp_ok,
  output logic [AW-1:0]       rsp_pa,
  output logic [1:0]          rsp_fault
);
  localparam int NSEG  = 1 << SEG_BITS;
  localparam int OFF_W = AW - SEG_BITS;
  localparam logic [1:0] F_NONE = 2'd0, F_ABSENT = 2'd1, F_LIMIT = 2'd2, F_PROT = 2'd3;

  logic [NSEG-1:0]  t_present, t_wr_ok;
  logic [AW-1:0]    t_base  [NSEG];
  logic [OFF_W-1:0] t_limit [NSEG];

  logic [SEG_BITS-1:0] seg;
  logic [OFF_W-1:0]    off;
  logic [AW-1:0]       sum;
  logic [1:0]          fault;

  assign seg = req_va[AW-1 -: SEG_BITS];
  assign off = req_va[OFF_W-1:0];
  assign sum = t_base[seg] + {{SEG_BITS{1'b0}}, off};

  always_comb begin
    if (!t_present[seg])                  fault = F_ABSENT;
    else if (off > t_limit[seg])          fault = F_LIMIT;
    else if (req_write && !t_wr_ok[seg])  fault = F_PROT;
    else                                  fault = F_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_present <= '0;
      t_wr_ok   <= '0;
      for (int i = 0; i < NSEG; i++) begin
        t_base[i]  <= '0;
        t_limit[i] <= '0;
      end
    end else if (cfg_we && cfg_priv) begin
      t_present[cfg_idx] <= cfg_present;
      t_wr_ok[cfg_idx]   <= cfg_wr_ok;
      t_base[cfg_idx]    <= cfg_base;
      t_limit[cfg_idx]   <= cfg_limit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_pa    <= '0;
      rsp_fault <= F_NONE;
    end else begin
      rsp_valid <= req_valid;
      rsp_ok    <= req_valid && (fault == F_NONE);
      rsp_pa    <= (req_valid && fault == F_NONE) ? sum : '0;
      rsp_fault <= req_valid ? fault : F_NONE;
    end
  end
endmodule

module seg_xlate_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic          rsp_valid,
  input logic          rsp_ok,
  input logic [AW-1:0] rsp_pa,
  input logic [1:0]    rsp_fault
);
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault != 2'd0) |-> (!rsp_ok && rsp_pa == '0)); // R7
  AST_OK_MATCHES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_ok == (rsp_fault == 2'd0))); // R2
  AST_REQ_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_ok && rsp_fault == 2'd0 && rsp_pa == '0)); // R8
  AST_PROT_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd3) |-> $past(req_write)); // R5
endmodule

bind seg_xlate seg_xlate_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault)
);

// File: tb/seg_xlate_test.sv
module seg_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_va = '0;
  logic        cfg_we = 1'b0, cfg_priv = 1'b0, cfg_present = 1'b0, cfg_wr_ok = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_base = '0;
  logic [29:0] cfg_limit = '0;
  logic        rsp_valid, rsp_ok;
  logic [31:0] rsp_pa;
  logic [1:0]  rsp_fault;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  seg_xlate uut (.*);

  task automatic expect_rsp(input string tag, input logic ev, input logic eok,
                            input logic [31:0] epa, input logic [1:0] ef);
    checks++;
    if (rsp_valid !== ev || rsp_ok !== eok || rsp_pa !== epa || rsp_fault !== ef) begin
      errors++;
      $display("FAIL %s: got v=%0b ok=%0b pa=%h f=%0d, expected v=%0b ok=%0b pa=%h f=%0d",
               tag, rsp_valid, rsp_ok, rsp_pa, rsp_fault, ev, eok, epa, ef);
    end
  endtask

  task automatic xl(input logic [31:0] va, input logic wr, input logic eok,
                    input logic [31:0] epa, input logic [1:0] ef, input string tag);
    @(negedge clk); req_valid = 1'b1; req_va = va; req_write = wr;
    @(negedge clk); req_valid = 1'b0; req_write = 1'b0;
    expect_rsp(tag, 1'b1, eok, epa, ef);
  endtask

  task automatic wr_entry(input logic priv, input logic [1:0] idx, input logic pres,
                          input logic [31:0] base, input logic [29:0] lim, input logic wok);
    @(negedge clk);
    cfg_we = 1'b1; cfg_priv = priv; cfg_idx = idx; cfg_present = pres;
    cfg_base = base; cfg_limit = lim; cfg_wr_ok = wok;
    @(negedge clk); cfg_we = 1'b0; cfg_priv = 1'b0;
  endtask

  task automatic t_reset;
    expect_rsp("R11 idle after reset", 1'b0, 1'b0, 32'h0, 2'd0);
    xl(32'h0000_0010, 1'b0, 1'b0, 32'h0, 2'd1, "R11 seg0 absent after reset");
    xl(32'hC000_0000, 1'b0, 1'b0, 32'h0, 2'd1, "R11 seg3 absent after reset");
  endtask

  task automatic t_load;
    wr_entry(1'b1, 2'd0, 1'b1, 32'h0000_4000, 30'h6FF, 1'b0);
    wr_entry(1'b1, 2'd1, 1'b1, 32'h0000_0000, 30'h4FF, 1'b1);
    wr_entry(1'b1, 2'd3, 1'b1, 32'h0000_2000, 30'hFFF, 1'b1);
  endtask

  task automatic t_translate;
    xl(32'h0000_0010, 1'b0, 1'b1, 32'h0000_4010, 2'd0, "R2 seg0 read");
    xl(32'h4000_0123, 1'b1, 1'b1, 32'h0000_0123, 2'd0, "R2 seg1 write");
    xl(32'hC000_0123, 1'b0, 1'b1, 32'h0000_2123, 2'd0, "R1 seg3 from top bits");
    xl(32'h0000_06FF, 1'b0, 1'b1, 32'h0000_46FF, 2'd0, "R4 offset equal limit");
  endtask

  task automatic t_faults;
    xl(32'h0000_0700, 1'b0, 1'b0, 32'h0, 2'd2, "R4 offset past limit");
    xl(32'h4000_0500, 1'b1, 1'b0, 32'h0, 2'd2, "R4 seg1 past limit");
    xl(32'h0000_0005, 1'b1, 1'b0, 32'h0, 2'd3, "R5 write read-only");
    xl(32'h0000_0005, 1'b0, 1'b1, 32'h0000_4005, 2'd0, "R5 read read-only");
    xl(32'h8000_0000, 1'b0, 1'b0, 32'h0, 2'd1, "R3 absent segment");
    xl(32'h0000_0800, 1'b1, 1'b0, 32'h0, 2'd2, "R6 limit before protect");
    xl(32'hBFFF_FFFF, 1'b1, 1'b0, 32'h0, 2'd1, "R6 absent before limit");
    xl(32'hC000_1000, 1'b0, 1'b0, 32'h0, 2'd2, "R7 fault gives zero address");
  endtask

  task automatic t_idle;
    @(negedge clk);
    expect_rsp("R8 no request no response", 1'b0, 1'b0, 32'h0, 2'd0);
  endtask

  task automatic t_user_write;
    wr_entry(1'b0, 2'd2, 1'b1, 32'h0001_0000, 30'hFFFF, 1'b1);
    xl(32'h8000_0010, 1'b0, 1'b0, 32'h0, 2'd1, "R9 user write ignored");
    wr_entry(1'b0, 2'd0, 1'b1, 32'h0000_7000, 30'h6FF, 1'b1);
    xl(32'h0000_0010, 1'b1, 1'b0, 32'h0, 2'd3, "R9 user write left entry");
  endtask

  task automatic t_same_edge;
    @(negedge clk);
    req_valid = 1'b1; req_va = 32'h4000_0010; req_write = 1'b0;
    cfg_we = 1'b1; cfg_priv = 1'b1; cfg_idx = 2'd1; cfg_present = 1'b1;
    cfg_base = 32'h0000_9000; cfg_limit = 30'h4FF; cfg_wr_ok = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0; cfg_priv = 1'b0;
    expect_rsp("R10 old entry used", 1'b1, 1'b1, 32'h0000_0010, 2'd0);
    xl(32'h4000_0010, 1'b0, 1'b1, 32'h0000_9010, 2'd0, "R10 new entry after");
  endtask

  task automatic t_switch;
    wr_entry(1'b1, 2'd0, 1'b0, 32'h0, 30'h0, 1'b0);
    wr_entry(1'b1, 2'd1, 1'b1, 32'h0010_0000, 30'h0FF, 1'b0);
    wr_entry(1'b1, 2'd2, 1'b1, 32'h0020_0000, 30'h3FFF_FFFF, 1'b1);
    wr_entry(1'b1, 2'd3, 1'b1, 32'hFFFF_FFF0, 30'hFFF, 1'b1);
    xl(32'h0000_0010, 1'b0, 1'b0, 32'h0, 2'd1, "R12 seg0 now absent");
    xl(32'h4000_0020, 1'b1, 1'b0, 32'h0, 2'd3, "R12 seg1 now read-only");
    xl(32'h4000_0100, 1'b0, 1'b0, 32'h0, 2'd2, "R12 seg1 new limit");
    xl(32'hBFFF_FFFF, 1'b1, 1'b1, 32'h401F_FFFF, 2'd0, "R12 seg2 full range");
    xl(32'hC000_0020, 1'b0, 1'b1, 32'h0000_0010, 2'd0, "R2 base plus offset wraps");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_translate();
    t_faults();
    t_idle();
    t_user_write();
    t_same_edge();
    t_switch();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule